// File: doc/BRIEF.md
# Serial CODEC Audio Link

This block connects a host to an external 8-bit audio CODEC over a four-wire serial link that runs in both directions at once. The host pushes bytes into a 16-entry transmit queue and pops received bytes from a 16-entry receive queue. Each queue reports full and empty. On the pin side the block drives a bit clock, a frame-sync strobe and serial data out, and it samples serial data in.

The bit clock comes from the block's own clock through a programmable divider, and the same bit clock serves both directions. Each frame lasts nine bit-clock periods. The first period is a sync slot in which the frame-sync strobe is high and data out is zero. Eight data slots follow, most significant bit first. Outgoing bits change where the bit clock rises. Incoming bits are captured where it falls.

Two sticky flags report queue trouble. The underrun flag is set when a frame starts while the transmit queue is empty; that frame sends zero. The overrun flag is set when a byte arrives while the receive queue is full; that byte is dropped. Deasserting enable stops the link and clears both flags. The contents of the queues are kept.

Top module: `codec_serial_link`

## Requirements
- R1: After reset the bit clock, frame sync and data out are low, both queues are empty and not full, and both sticky flags are clear.
- R2: With enable high and divider value N, the bit clock has a period of 2*(N+1) clock cycles. With enable low, the bit clock stays low.
- R3: The frame-sync strobe is high for exactly one bit-clock period. It runs from one bit-clock rise to the next and sits directly before the first data bit. Consecutive sync rises are 9 bit-clock periods apart.
- R4: Data out and frame sync change only in the clock cycle in which the bit clock rises. Each byte goes out most significant bit first, in the eight slots after the sync slot.
- R5: Data in is captured at each bit-clock fall in a data slot, most significant bit first. The completed byte is queued at the fall of the eighth data slot.
- R6: The transmit queue holds 16 bytes and then reports full. A write while full is ignored and does not reach the line.
- R7: The receive queue holds 16 bytes and then reports full. A byte that arrives while it is full is dropped, the overrun flag is set, and the stored bytes stay unchanged.
- R8: When a frame starts with the transmit queue empty, the data slots carry zero and the underrun flag is set. It stays set while enable is high.
- R9: Deasserting enable clears both sticky flags and drives the bit clock low. The queue contents are kept.
- R10: Transmit and receive run at the same time. With data out looped back to data in, the receive queue returns the bytes written, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock, source of the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the link; low stops it and clears the flags |
| div_i | input | DIV_W | Divider value N; bit-clock period is 2*(N+1) cycles |
| tx_wr_i | input | 1 | Write strobe for the transmit queue |
| tx_data_i | input | DATA_W | Byte to queue for sending |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_rd_i | input | 1 | Pop strobe for the receive queue |
| rx_data_o | output | DATA_W | Oldest received byte (valid when not empty) |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| underrun_o | output | 1 | Sticky: a frame started with no byte queued |
| overrun_o | output | 1 | Sticky: a received byte was dropped |
| bclk_o | output | 1 | Bit clock to the CODEC |
| fsync_o | output | 1 | Frame-sync strobe, one bit period before the MSB |
| sdo_o | output | 1 | Serial data to the CODEC |
| sdi_i | input | 1 | Serial data from the CODEC |

## Verification
The bench uses the default widths: 8-bit data, 16-entry queues and an 8-bit divider. It steps the divider through 0, 1, 2 and 3, so both the degenerate case in which the bit clock toggles every cycle and wider periods are measured from the pins. Divider 0 makes a frame only 18 cycles long. At that rate the bench can write seventeen bytes, fill the receive queue through loopback and push it into overrun within a few hundred cycles. A pin-side decoder rebuilds each transmitted byte from the sync strobe and data out, so dropped writes and zero underrun frames are visible without looking inside the block.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;

    // Position of the frame engine inside a frame
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // link just enabled, no frame started yet
        PH_SYNC = 2'd1,   // sync slot: strobe high, data out zero
        PH_DATA = 2'd2    // one of the data slots
    } link_phase_e;

endpackage

// File: rtl/codec_link_fifo.sv
module codec_link_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty_o = (ptr_q.wptr == ptr_q.rptr);
    assign full_o  = (ptr_q.wptr[AW] != ptr_q.rptr[AW]) &&
                     (ptr_q.wptr[AW-1:0] == ptr_q.rptr[AW-1:0]);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem_q[ptr_q.rptr[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wptr = ptr_q.wptr + 1'b1;
        if (do_pop)  ptr_d.rptr = ptr_q.rptr + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ptr_q <= '0;
        else         ptr_q <= ptr_d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[ptr_q.wptr[AW-1:0]] <= wdata_i;
    end

    // R6 R7
    push_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i) |=> $stable(ptr_q.wptr));

    // R6 R7
    level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ptr_q.wptr - ptr_q.rptr) <= (AW+1)'(DEPTH)));

endmodule

// File: rtl/codec_link_bclk_gen.sv
module codec_link_bclk_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick_w;

    // A tick ends a half period of N+1 cycles
    assign tick_w = enable_i && (gen_q.cnt == div_i);
    assign rise_o = tick_w && !gen_q.bclk;
    assign fall_o = tick_w && gen_q.bclk;
    assign bclk_o = gen_q.bclk;

    always_comb begin
        gen_d = gen_q;
        if (!enable_i) begin
            gen_d = '0;
        end else if (tick_w) begin
            gen_d.cnt  = '0;
            gen_d.bclk = !gen_q.bclk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= '0;
        else         gen_q <= gen_d;
    end

    // R2
    bclk_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !bclk_o);

    // R2
    bclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !tick_w) |=> $stable(bclk_o));

endmodule

// File: rtl/codec_link_framer.sv
module codec_link_framer
    import codec_link_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic              sdi_i,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              fsync_o,
    output logic              sdo_o,
    output logic              underrun_o,
    output logic              overrun_o
);

    localparam int unsigned SLOT_W = $clog2(DATA_W + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DATA_W);

    typedef struct packed {
        link_phase_e       phase;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] txsh;
        logic [DATA_W-1:0] rxsh;
        logic              fsync;
        logic              sdo;
        logic              underrun;
        logic              overrun;
    } frm_t;

    frm_t frm_d, frm_q;
    logic frame_start_w;

    // New frame when idle or after the last data slot
    assign frame_start_w = (frm_q.phase == PH_IDLE) ||
                           ((frm_q.phase == PH_DATA) && (frm_q.slot == LAST_SLOT));

    assign rx_data_o  = {frm_q.rxsh[DATA_W-2:0], sdi_i};
    assign fsync_o    = frm_q.fsync;
    assign sdo_o      = frm_q.sdo;
    assign underrun_o = frm_q.underrun;
    assign overrun_o  = frm_q.overrun;

    always_comb begin
        frm_d     = frm_q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        if (!enable_i) begin
            frm_d       = '0;
            frm_d.phase = PH_IDLE;
        end else begin
            if (rise_i) begin
                if (frame_start_w) begin
                    frm_d.phase = PH_SYNC;
                    frm_d.slot  = '0;
                    frm_d.fsync = 1'b1;
                    frm_d.sdo   = 1'b0;
                    if (tx_empty_i) begin
                        frm_d.txsh     = '0;
                        frm_d.underrun = 1'b1;
                    end else begin
                        frm_d.txsh = tx_data_i;
                        tx_pop_o   = 1'b1;
                    end
                end else begin
                    frm_d.phase = PH_DATA;
                    frm_d.slot  = frm_q.slot + 1'b1;
                    frm_d.fsync = 1'b0;
                    frm_d.sdo   = frm_q.txsh[DATA_W-1];
                    frm_d.txsh  = {frm_q.txsh[DATA_W-2:0], 1'b0};
                end
            end
            if (fall_i && (frm_q.phase == PH_DATA)) begin
                frm_d.rxsh = {frm_q.rxsh[DATA_W-2:0], sdi_i};
                if (frm_q.slot == LAST_SLOT) begin
                    if (rx_full_i) frm_d.overrun = 1'b1;
                    else           rx_push_o     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) frm_q <= '0;
        else         frm_q <= frm_d;
    end

    // R3
    fsync_one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_q.fsync && rise_i) |=> !fsync_o);

    // R4
    sdo_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !rise_i) |=> ($stable(sdo_o) && $stable(fsync_o)));

    // R8
    underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (underrun_o && enable_i) |=> underrun_o);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (overrun_o && enable_i) |=> overrun_o);

endmodule

// File: rtl/codec_serial_link.sv
module codec_serial_link #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned DIV_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              rx_empty_o,
    output logic              underrun_o,
    output logic              overrun_o,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              sdo_o,
    input  logic              sdi_i
);

    logic              rise_w, fall_w;
    logic              tx_pop_w, rx_push_w;
    logic [DATA_W-1:0] tx_head_w, rx_word_w;

    codec_link_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .div_i    (div_i),
        .bclk_o   (bclk_o),
        .rise_o   (rise_w),
        .fall_o   (fall_w)
    );

    codec_link_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (tx_wr_i),
        .wdata_i (tx_data_i),
        .pop_i   (tx_pop_w),
        .rdata_o (tx_head_w),
        .full_o  (tx_full_o),
        .empty_o (tx_empty_o)
    );

    codec_link_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (rx_push_w),
        .wdata_i (rx_word_w),
        .pop_i   (rx_rd_i),
        .rdata_o (rx_data_o),
        .full_o  (rx_full_o),
        .empty_o (rx_empty_o)
    );

    codec_link_framer #(.DATA_W(DATA_W)) u_framer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .tx_data_i  (tx_head_w),
        .tx_empty_i (tx_empty_o),
        .rx_full_i  (rx_full_o),
        .sdi_i      (sdi_i),
        .tx_pop_o   (tx_pop_w),
        .rx_push_o  (rx_push_w),
        .rx_data_o  (rx_word_w),
        .fsync_o    (fsync_o),
        .sdo_o      (sdo_o),
        .underrun_o (underrun_o),
        .overrun_o  (overrun_o)
    );

    // R9
    flags_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!underrun_o && !overrun_o && !fsync_o && !sdo_o));

endmodule

// File: tb/codec_serial_link_tb_top.sv
`timescale 1ns/1ps
module codec_serial_link_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] div = 8'd0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       rx_rd = 1'b0;
    logic       tx_full, tx_empty, rx_full, rx_empty, underrun, overrun;
    logic [7:0] rx_data;
    logic       bclk, fsync, sdo, sdi;
    logic       mon_rst = 1'b1;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz
    assign sdi = sdo;       // loopback

    codec_serial_link dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .div_i(div),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
        .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
        .underrun_o(underrun), .overrun_o(overrun),
        .bclk_o(bclk), .fsync_o(fsync), .sdo_o(sdo), .sdi_i(sdi)
    );

    // Pin-side monitor
    int   cyc = 0, last_rise = 0, rises = 0, period = 0;
    int   fs_start = 0, fs_width = 0, last_sync = 0, frame_len = 0, sync_cnt = 0;
    int   edge_viol = 0, bitn = 0, mon_n = 0;
    bit   collecting = 1'b0;
    logic bclk_p = 1'b0, fsync_p = 1'b0, sdo_p = 1'b0, en_p = 1'b0;
    logic [7:0] cur = 8'd0;
    logic [7:0] mon_bytes [32];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_rst) begin
            rises = 0; period = 0; fs_width = 0; frame_len = 0; sync_cnt = 0;
            edge_viol = 0; mon_n = 0; collecting = 1'b0; bitn = 0;
        end else begin
            if (en_p && enable && !(bclk && !bclk_p) && (sdo !== sdo_p || fsync !== fsync_p))
                edge_viol = edge_viol + 1;
            if (bclk && !bclk_p) begin
                if (rises > 0) period = cyc - last_rise;
                last_rise = cyc;
                rises = rises + 1;
                if (fsync) begin
                    collecting = 1'b1; bitn = 0;
                end else if (collecting) begin
                    cur = {cur[6:0], sdo};
                    bitn = bitn + 1;
                    if (bitn == 8) begin
                        if (mon_n < 32) mon_bytes[mon_n] = cur;
                        mon_n = mon_n + 1;
                        collecting = 1'b0;
                    end
                end
            end
            if (fsync && !fsync_p) begin
                if (sync_cnt > 0) frame_len = cyc - last_sync;
                last_sync = cyc; fs_start = cyc;
                sync_cnt = sync_cnt + 1;
            end
            if (!fsync && fsync_p) fs_width = cyc - fs_start;
        end
        bclk_p = bclk; fsync_p = fsync; sdo_p = sdo; en_p = enable;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
        #1;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
        #1;
    endtask

    task automatic wait_syncs(input int n);
        while (sync_cnt < n) @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_rst = 1'b1;
        @(negedge clk); mon_rst = 1'b0;
        #1;
    endtask

    task automatic drain_rx();
        for (int i = 0; i < 20; i++) if (!rx_empty) pop_rx();
    endtask

    // {divider, first byte, second byte}
    localparam logic [23:0] VECS [4] = '{24'h00A53C, 24'h01817E, 24'h03FF00, 24'h025AC3};

    initial begin
        tick(3);
        // R1 reset state
        chk(!bclk && !fsync && !sdo, "R1 pins low", {bclk, fsync, sdo}, 0);
        chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 queues empty",
            {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        chk(!underrun && !overrun, "R1 flags clear", {underrun, overrun}, 0);
        rst_n = 1'b1;
        tick(20);
        // R2 disabled: bit clock stays low
        chk(!bclk && rises == 0, "R2 bclk low while disabled", rises, 0);

        for (int v = 0; v < 4; v++) begin
            int n;
            logic [7:0] b0, b1, got;
            n  = int'(VECS[v][23:16]);
            b0 = VECS[v][15:8];
            b1 = VECS[v][7:0];
            enable = 1'b0;
            div = VECS[v][23:16];
            clear_mon();
            write_tx(b0);
            write_tx(b1);
            @(negedge clk); enable = 1'b1;
            wait_syncs(3);
            chk(period == 2 * (n + 1), "R2 bclk period", period, 2 * (n + 1));
            chk(fs_width == 2 * (n + 1), "R3 sync width", fs_width, 2 * (n + 1));
            chk(frame_len == 18 * (n + 1), "R3 frame length", frame_len, 18 * (n + 1));
            chk(mon_n >= 2 && mon_bytes[0] == b0, "R4 first byte on line", mon_bytes[0], b0);
            chk(mon_bytes[1] == b1, "R4 second byte on line", mon_bytes[1], b1);
            chk(edge_viol == 0, "R4 outputs move only at rise", edge_viol, 0);
            chk(underrun == 1'b1, "R8 underrun after queue ran dry", underrun, 1);
            got = rx_data;
            chk(!rx_empty && got == b0, "R10 R5 loopback first byte", got, b0);
            pop_rx();
            got = rx_data;
            chk(!rx_empty && got == b1, "R10 R5 loopback second byte", got, b1);
            enable = 1'b0;
            tick(3);
            chk(!bclk && !underrun, "R9 disable clears underrun", {bclk, underrun}, 0);
            drain_rx();
        end

        // R8 underrun frame carries zero (checked on line)
        div = 8'd1;
        clear_mon();
        @(negedge clk); enable = 1'b1;
        wait_syncs(2);
        chk(mon_n >= 1 && mon_bytes[0] == 8'h00, "R8 zero frame", mon_bytes[0], 0);
        chk(underrun, "R8 underrun on first empty frame", underrun, 1);
        enable = 1'b0;
        tick(3);
        drain_rx();

        // R6 / R7 queue limits
        div = 8'd0;
        clear_mon();
        for (int i = 0; i < 16; i++) write_tx(8'h10 + 8'(i));
        chk(tx_full, "R6 tx full after 16", tx_full, 1);
        write_tx(8'hEE);
        chk(tx_full, "R6 tx still full after extra write", tx_full, 1);
        @(negedge clk); enable = 1'b1;
        wait_syncs(18);
        chk(mon_bytes[15] == 8'h1F, "R6 sixteenth byte sent", mon_bytes[15], 8'h1F);
        chk(mon_bytes[16] == 8'h00, "R6 extra write ignored", mon_bytes[16], 0);
        chk(rx_full, "R7 rx full", rx_full, 1);
        chk(overrun, "R7 overrun set", overrun, 1);
        chk(rx_data == 8'h10, "R7 oldest byte kept", rx_data, 8'h10);
        enable = 1'b0;
        tick(3);
        chk(!overrun && rx_full, "R9 overrun cleared, queue kept", {overrun, rx_full}, 1);
        begin
            int bad = 0;
            for (int i = 0; i < 16; i++) begin
                if (rx_data != 8'h10 + 8'(i)) bad++;
                pop_rx();
            end
            chk(bad == 0, "R7 stored bytes unchanged", bad, 0);
        end
        chk(rx_empty, "R7 rx empty after 16 pops", rx_empty, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule